// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Unit

This block forms dot products of signed fractional data. Each accepted operand pair holds two Q1.15 numbers, which span −1 up to one step below +1. The pair is multiplied into a Q1.31 product. The product is then added to a running sum that carries 8 guard bits above the Q1.31 range, for 40 bits in all. A start flag sent with a pair loads the sum with that pair's product, so each new dot product needs no separate reset cycle.

Every accepted pair yields one narrowed 16-bit result. The result is the running sum rounded at bit 15 and clamped to the Q1.15 range. A sticky overflow flag records whether any clamp has happened since the last start. The pipeline has three register stages: multiply, accumulate and narrow. A result therefore appears three clock edges after its operand pair is accepted. Fetching the vectors from memory is left to the surrounding logic.

Top module: `sat_mac`

## Requirements
- R1: While rst_ni is low, and after it is released until the first result, result_o is 0, res_valid_o is 0 and ovf_o is 0.
- R2: A pair taken with valid_i=1 and start_i=1 loads the accumulator with the Q1.31 product, which is 2·a·b taken as signed integers. The previous sum is discarded.
- R3: The one product that cannot be represented, 0x8000 × 0x8000 (−1 × −1), is replaced by 0x7FFF_FFFF before it is accumulated.
- R4: A pair taken with valid_i=1 and start_i=0 adds its product to the accumulator.
- R5: The 40-bit accumulator saturates to +2^39−1 or −2^39 instead of wrapping when a sum leaves its range.
- R6: The result is floor((acc + 2^15) / 2^16). This is round-half-up, so a tie at −0.5 LSB goes to 0 and a tie at +0.5 LSB goes to 1.
- R7: When the rounded value does not fit in 16 signed bits, result_o is clamped to 0x7FFF (positive) or 0x8000 (negative).
- R8: ovf_o goes to 1 with any result that was clamped. It stays 1 through later results until a start pair arrives. A start pair's own result sets ovf_o to whether that result was clamped, so a clamp in the same result wins over the clear.
- R9: res_valid_o is 1 exactly three clock edges after each accepted pair. While valid_i=0, start_i and the operands have no effect, and result_o and ovf_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair is present this cycle |
| start_i | input | 1 | With valid_i: begin a new sum with this pair |
| a_i | input | 16 | Operand A, Q1.15 signed |
| b_i | input | 16 | Operand B, Q1.15 signed |
| result_o | output | 16 | Rounded and clamped sum, Q1.15 |
| res_valid_o | output | 1 | result_o holds a new value |
| ovf_o | output | 1 | Sticky clamp flag since the last start |

## Verification
Two functions can fall on the same result: the start pair clearing the sticky flag, and that same pair's rounded value being clamped. The bench provokes this by first setting the flag with a negative clamp. It then sends a start pair of −1 × −1, whose value rounds past +1. The scoreboard requires ovf_o to remain 1 on that result. A following start pair that does not clamp must bring ovf_o back to 0. A long run of −1 × −1 products also pushes the accumulator into its own 40-bit clamp. The bench then checks that the output keeps reading 0x7FFF, where a wrapped sum would read 0x8000.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef struct packed {
    logic vld;
    logic clr;
  } mac_ctl_t;
endpackage

// File: rtl/sat_mac_mul.sv
module sat_mac_mul
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  mac_ctl_t                 ctl_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [PROD_W-1:0] prod_o,
  output mac_ctl_t                 ctl_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext, raw, prod_d;
  logic both_min;

  assign a_ext = {{DATA_W{a_i[DATA_W-1]}}, a_i};
  assign b_ext = {{DATA_W{b_i[DATA_W-1]}}, b_i};
  assign raw   = a_ext * b_ext;
  // -1 x -1 is the only product outside Q1.31
  assign both_min = (a_i == {1'b1, {(DATA_W-1){1'b0}}}) &&
                    (b_i == {1'b1, {(DATA_W-1){1'b0}}});
  assign prod_d = both_min ? {1'b0, {(PROD_W-1){1'b1}}} : (raw <<< 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
      ctl_o  <= '0;
    end else begin
      ctl_o <= ctl_i;
      if (ctl_i.vld) prod_o <= prod_d;
    end
  end
endmodule

// File: rtl/sat_mac_acc.sv
module sat_mac_acc
  import sat_mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8,
  localparam int PROD_W = 2 * DATA_W,
  localparam int ACC_W  = PROD_W + GUARD_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  mac_ctl_t                 ctl_i,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic signed [ACC_W-1:0]  acc_o,
  output mac_ctl_t                 ctl_o
);
  logic signed [ACC_W-1:0] base, acc_d;
  logic signed [ACC_W:0]   sum;

  assign base = ctl_i.clr ? '0 : acc_o;
  assign sum  = {base[ACC_W-1], base} + {{(GUARD_W+1){prod_i[PROD_W-1]}}, prod_i};

  always_comb begin
    acc_d = sum[ACC_W-1:0];
    if (sum[ACC_W] != sum[ACC_W-1])
      acc_d = sum[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ctl_o <= '0;
    end else begin
      ctl_o <= ctl_i;
      if (ctl_i.vld) acc_o <= acc_d;
    end
  end
endmodule

// File: rtl/sat_mac_out.sv
module sat_mac_out
  import sat_mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8,
  localparam int PROD_W = 2 * DATA_W,
  localparam int ACC_W  = PROD_W + GUARD_W,
  localparam int HI_W   = ACC_W - PROD_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  mac_ctl_t                 ctl_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic        [DATA_W-1:0] res_o,
  output logic                     vld_o,
  output logic                     ovf_o
);
  logic signed [ACC_W:0] rnd;
  logic [HI_W-1:0]   hi;
  logic [DATA_W-1:0] res_d;
  logic              sat_pos, sat_neg;

  assign rnd     = {acc_i[ACC_W-1], acc_i} + (ACC_W+1)'(1 << (DATA_W - 1));
  // result fits when bits ACC_W..PROD_W-1 are all equal
  assign hi      = rnd[ACC_W:PROD_W-1];
  assign sat_pos = !rnd[ACC_W] && (|hi);
  assign sat_neg =  rnd[ACC_W] && !(&hi);

  always_comb begin
    res_d = rnd[PROD_W-1:DATA_W];
    if (sat_pos) res_d = {1'b0, {(DATA_W-1){1'b1}}};
    if (sat_neg) res_d = {1'b1, {(DATA_W-1){1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      vld_o <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      vld_o <= ctl_i.vld;
      if (ctl_i.vld) begin
        res_o <= res_d;
        ovf_o <= (ovf_o && !ctl_i.clr) || sat_pos || sat_neg;
      end
    end
  end
endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              res_valid_o,
  output logic              ovf_o
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;

  mac_ctl_t ctl_in, ctl_mul, ctl_acc;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc;

  assign ctl_in.vld = valid_i;
  assign ctl_in.clr = start_i;

  sat_mac_mul #(.DATA_W(DATA_W)) u_mul (
    .clk_i (clk_i), .rst_ni(rst_ni), .ctl_i(ctl_in),
    .a_i   ($signed(a_i)), .b_i($signed(b_i)),
    .prod_o(prod), .ctl_o(ctl_mul)
  );

  sat_mac_acc #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl_mul),
    .prod_i(prod), .acc_o(acc), .ctl_o(ctl_acc)
  );

  sat_mac_out #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl_acc), .acc_i(acc),
    .res_o(result_o), .vld_o(res_valid_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/sat_mac_chk.sv
module sat_mac_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              start_i,
  input logic [DATA_W-1:0] result_o,
  input logic              res_valid_o,
  input logic              ovf_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !res_valid_o && !ovf_o)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##3 res_valid_o); // R9

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##3 !res_valid_o); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> ($stable(result_o) && $stable(ovf_o))); // R9

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (ovf_o || res_valid_o)); // R8

  AST_OVF_RISE_CLAMPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (res_valid_o &&
      (result_o == {1'b0, {(DATA_W-1){1'b1}}} || result_o == {1'b1, {(DATA_W-1){1'b0}}}))); // R7
endmodule

bind sat_mac sat_mac_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .start_i(start_i),
  .result_o(result_o), .res_valid_o(res_valid_o), .ovf_o(ovf_o)
);

// File: tb/sat_mac_tb_top.sv
`timescale 1ns/1ps
module sat_mac_tb_top;
  typedef struct {
    logic [15:0] res;
    logic        ovf;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, start = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] result;
  logic res_valid, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];
  longint acc_m = 0;
  bit ovf_m = 1'b0;

  always #2 clk = ~clk;

  sat_mac dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .start_i(start),
    .a_i(a), .b_i(b), .result_o(result), .res_valid_o(res_valid), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] av, input logic [15:0] bv, input bit clr, input string req);
    longint p, r, q;
    exp_t e;
    bit sat;
    p = 2 * longint'($signed(av)) * longint'($signed(bv));
    if (av == 16'h8000 && bv == 16'h8000) p = 64'sh7FFF_FFFF;    // R3
    acc_m = clr ? p : acc_m + p;                                 // R2 R4
    if (acc_m > 64'sh7F_FFFF_FFFF) acc_m = 64'sh7F_FFFF_FFFF;    // R5
    if (acc_m < -64'sh80_0000_0000) acc_m = -64'sh80_0000_0000;
    r = (acc_m + 32768) >>> 16;                                  // R6
    sat = 1'b0;
    if (r > 32767)  begin r = 32767;  sat = 1'b1; end            // R7
    if (r < -32768) begin r = -32768; sat = 1'b1; end
    q = r;
    ovf_m = (ovf_m && !clr) || sat;                              // R8
    e.res = q[15:0]; e.ovf = ovf_m; e.req = req;
    sb.push_back(e);
    valid = 1'b1; start = clr; a = av; b = bv;
    @(negedge clk);
    valid = 1'b0; start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9 unexpected result", longint'(result), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(result == e.res && ovf == e.ovf, e.req,
            {result, 3'b0, ovf}, {e.res, 3'b0, e.ovf});
      end
    end
  end

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    chk(result == 0 && !res_valid && !ovf, "R1 reset", {result, res_valid, ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == 0 && !res_valid && !ovf, "R1 after release", {result, res_valid, ovf}, 0);

    drive(16'h4000, 16'h4000, 1, "R2 start load 0.5*0.5");
    drive(16'h2000, 16'h4000, 0, "R4 accumulate");
    drive(16'h0001, 16'h4000, 1, "R6 tie +0.5 LSB");
    drive(16'hFFFF, 16'h4000, 1, "R6 tie -0.5 LSB");
    drive(16'h0003, 16'h4000, 1, "R6 tie +1.5 LSB");
    drive(16'hFFFD, 16'h4000, 1, "R6 tie -1.5 LSB");
    drive(16'h8000, 16'h8000, 1, "R3 R7 -1*-1 clamp");
    drive(16'h8000, 16'h4000, 0, "R8 sticky holds");
    drive(16'h4000, 16'h4000, 1, "R8 start clears");
    drive(16'h8000, 16'h7FFF, 1, "R2 near -1");
    drive(16'h8000, 16'h7FFF, 0, "R7 negative clamp");
    drive(16'h8000, 16'h8000, 1, "R8 clamp wins over clear");
    drive(16'h1234, 16'h0100, 1, "R8 clear without clamp");
    repeat (5) @(negedge clk);

    // long run into the accumulator limit
    drive(16'h8000, 16'h8000, 1, "R5 run start");
    for (int i = 0; i < 299; i++) drive(16'h8000, 16'h8000, 0, "R5 accumulator clamp");
    for (int i = 0; i < 4; i++) drive(16'h8000, 16'h7FFF, 0, "R5 no wrap after clamp");
    repeat (5) @(negedge clk);

    // mixed traffic with gaps
    lcg = 32'h1ACE_0001;
    for (int i = 0; i < 200; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[3:1] == 0) @(negedge clk);
      drive(lcg[31:16], lcg[23:8], (i % 8) == 0, "R4 mixed stream");
    end
    repeat (5) @(negedge clk);

    // idle inputs have no effect
    held = result;
    for (int i = 0; i < 6; i++) begin
      valid = 1'b0; start = 1'b1; a = 16'h8000; b = 16'h8000;
      @(negedge clk);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(result == held && !res_valid, "R9 idle hold result", result, held);
    chk(ovf == ovf_m, "R9 idle hold ovf", ovf, ovf_m);
    drive(16'h2000, 16'h2000, 0, "R9 accumulate after idle");
    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R9 all results seen", sb.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule